// File: doc/BRIEF.md
# Two-Mode Page Table Walker

This block turns a 32-bit linear address into a physical address by reading translation tables from memory, one level at a time, through a single read port. A caller presents the linear address, the table base register value, a paging-enable bit and a mode bit, then pulses `start_i`. The walker issues the reads the selected mode needs. It ends with a one-cycle `done_o` pulse carrying either the physical address or a fault together with the level at which the walk stopped.

Two table formats are handled by the same state machine. The short format is a two-level walk with 4-byte entries, 10/10/12 index split, and a 32-bit physical result. The long format is a three-level walk with 8-byte entries, 2/9/9/12 index split, a 4-entry top table, and a 36-bit physical result. Long entries arrive over the 32-bit read port as two reads. When paging is off, the linear address is returned directly and no memory is touched. Pages are always 4 KB.

Top module: `page_walker`

## Requirements
- R1: With `paging_en_i` low, an accepted start gives `done_o` on the next cycle with `fault_o` low, `phys_addr_o` equal to the linear address zero-extended to 36 bits, and no memory read.
- R2: In short mode (`ext_mode_i` low) the first read is at {4'h0, base[31:12], lin[31:22], 2'b00}. The second read is at {4'h0, E[31:12], lin[21:12], 2'b00}, where E is the first entry.
- R3: A successful short-mode walk returns {4'h0, E[31:12], lin[11:0]}, where E is the second entry.
- R4: In long mode the low words of the three entries are read at the following addresses. The top entry is at {4'h0, base[31:5], lin[31:30], 3'b000}. The middle entry is at {F0, lin[29:21], 3'b000} and the last at {F1, lin[20:12], 3'b000}. F0 and F1 are the 24-bit frames of the previous entries.
- R5: A long entry is read as two 32-bit reads: the low word at the 8-byte-aligned address first, then the high word at that address plus 4. Its frame is {high[3:0], low[31:12]}.
- R6: A successful long-mode walk returns {F2, lin[11:0]}, where F2 is the frame of the third entry.
- R7: Bit 0 of each entry (bit 0 of the low word in long mode) is a present flag. A clear flag ends the walk, once that entry is fully read, with `done_o` and `fault_o` high and `fault_level_o` set to the step index (0 for the first table). No further read follows.
- R8: Each read is a one-cycle `mem_req_o` pulse with `mem_addr_o`. The walker waits any number of cycles for `mem_rvalid_i` before the next request. A walk makes exactly 2 reads in short mode, or 6 in long mode, when no fault occurs.
- R9: After reset `busy_o`, `done_o` and `mem_req_o` are low. `busy_o` is high from the cycle after an accepted paging start until the result. `start_i` is ignored while busy. `done_o` is a one-cycle pulse seen with `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a translation (accepted only when idle) |
| lin_addr_i | input | 32 | Linear address to translate |
| base_i | input | 32 | Table base register value |
| paging_en_i | input | 1 | Paging enable; low means identity translation |
| ext_mode_i | input | 1 | 1 selects the three-level 8-byte-entry format |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Result is a not-present fault |
| fault_level_o | output | 2 | Step index at which a fault occurred |
| phys_addr_o | output | 36 | Translated physical address |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 36 | Read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |

## Verification
The bound checker watches several properties on every cycle. It checks that requests occur only while busy and last one cycle, that the result strobe comes with busy low, and that the identity path answers one cycle after its start. It also checks that the page offset survives every walk, that short-mode read addresses stay 4-byte aligned below 4 GB, and that fault levels stay within the mode's depth. The exact chain of read addresses, the order of low and high words, the assembled frames and the point where a walk stops on a missing entry depend on memory contents. Only the bench's sweeps show these, across both modes, several bases and linear addresses, memory latencies from zero to three cycles, and a fault placed at each level.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_ISSUE = 2'd1,
      WK_WAIT = 2'd2
   } walk_state_t;
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
   parameter int LIN_W      = 32,
   parameter int PA_W       = 36,
   parameter int PAGE_SHIFT = 12
) (
   input  logic                         ext_i,
   input  logic [1:0]                   step_i,
   input  logic                         hi_word_i,
   input  logic [LIN_W-1:0]             lin_i,
   input  logic [LIN_W-1:0]             base_i,
   input  logic [PA_W-PAGE_SHIFT-1:0]   frame_i,
   output logic [PA_W-1:0]              addr_o
);
   localparam int SHORT_SH    = 2;
   localparam int LONG_SH     = 3;
   localparam int SHORT_IDX_W = PAGE_SHIFT - SHORT_SH;
   localparam int LONG_IDX_W  = PAGE_SHIFT - LONG_SH;
   localparam int TOP_W       = LIN_W - PAGE_SHIFT - 2*LONG_IDX_W;
   localparam int TOP_ALIGN   = TOP_W + LONG_SH;
   localparam int PAD_W       = PA_W - LIN_W;

   logic [PA_W-1:0]       base_addr;
   logic [LONG_IDX_W-1:0] long_idx;

   always_comb begin
      long_idx = (step_i == 2'd1) ? lin_i[PAGE_SHIFT+LONG_IDX_W +: LONG_IDX_W]
                                  : lin_i[PAGE_SHIFT +: LONG_IDX_W];
      if (step_i == 2'd0) begin
         if (ext_i)
            base_addr = {{PAD_W{1'b0}}, base_i[LIN_W-1:TOP_ALIGN],
                         lin_i[LIN_W-1 -: TOP_W], {LONG_SH{1'b0}}};
         else
            base_addr = {{PAD_W{1'b0}}, base_i[LIN_W-1:PAGE_SHIFT],
                         lin_i[LIN_W-1 -: SHORT_IDX_W], {SHORT_SH{1'b0}}};
      end else if (ext_i) begin
         base_addr = {frame_i, long_idx, {LONG_SH{1'b0}}};
      end else begin
         base_addr = {frame_i, lin_i[PAGE_SHIFT +: SHORT_IDX_W], {SHORT_SH{1'b0}}};
      end
      addr_o = base_addr;
      addr_o[SHORT_SH] = base_addr[SHORT_SH] | (hi_word_i & ext_i);
   end

   logic unused_addr_bits;
   assign unused_addr_bits = ^{lin_i[PAGE_SHIFT-1:0], base_i[TOP_ALIGN-1:0]};
endmodule

// File: rtl/pgw_entry.sv
module pgw_entry #(
   parameter int PA_W       = 36,
   parameter int DATA_W     = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic                        ext_i,
   input  logic [DATA_W-1:0]           lo_i,
   input  logic [DATA_W-1:0]           rdata_i,
   output logic                        present_o,
   output logic [PA_W-PAGE_SHIFT-1:0]  frame_o
);
   localparam int HI_W = PA_W - DATA_W;

   generate
      if (HI_W > 0) begin : g_wide
         assign frame_o = ext_i ? {rdata_i[HI_W-1:0], lo_i[DATA_W-1:PAGE_SHIFT]}
                                : {{HI_W{1'b0}}, rdata_i[DATA_W-1:PAGE_SHIFT]};
      end else begin : g_flat
         assign frame_o = ext_i ? lo_i[DATA_W-1:PAGE_SHIFT]
                                : rdata_i[DATA_W-1:PAGE_SHIFT];
      end
   endgenerate

   assign present_o = ext_i ? lo_i[0] : rdata_i[0];

   logic unused_entry_bits;
   assign unused_entry_bits = ^{lo_i[PAGE_SHIFT-1:1], rdata_i[PAGE_SHIFT-1:0]};
endmodule

// File: rtl/page_walker.sv
module page_walker #(
   parameter int LIN_W      = 32,
   parameter int PA_W       = 36,
   parameter int DATA_W     = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LIN_W-1:0]  lin_addr_i,
   input  logic [LIN_W-1:0]  base_i,
   input  logic              paging_en_i,
   input  logic              ext_mode_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              fault_o,
   output logic [1:0]        fault_level_o,
   output logic [PA_W-1:0]   phys_addr_o,
   output logic              mem_req_o,
   output logic [PA_W-1:0]   mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i
);
   import pgw_pkg::*;

   localparam int FRM_W       = PA_W - PAGE_SHIFT;
   localparam int PAD_W       = PA_W - LIN_W;
   localparam int SHORT_IDX_W = PAGE_SHIFT - 2;
   localparam int LONG_IDX_W  = PAGE_SHIFT - 3;
   localparam int TOP_W       = LIN_W - PAGE_SHIFT - 2*LONG_IDX_W;

   generate
      if (DATA_W != LIN_W) begin : g_bad_data
         $error("page_walker: DATA_W must equal LIN_W");
      end
      if (LIN_W != PAGE_SHIFT + 2*SHORT_IDX_W) begin : g_bad_short
         $error("page_walker: short format must split LIN_W into two full tables");
      end
      if (TOP_W < 1 || TOP_W > 3) begin : g_bad_top
         $error("page_walker: long-format top index width out of range");
      end
      if (PAD_W < 1 || PAD_W >= DATA_W - PAGE_SHIFT) begin : g_bad_pa
         $error("page_walker: PA_W must exceed LIN_W by a few bits");
      end
   endgenerate

   walk_state_t      state_q;
   logic [1:0]       step_q;
   logic             hi_q;
   logic             ext_q;
   logic [LIN_W-1:0] lin_q;
   logic [LIN_W-1:0] base_q;
   logic [FRM_W-1:0] frame_q;
   logic [DATA_W-1:0] lo_q;

   logic             present;
   logic [FRM_W-1:0] frame_new;
   logic [1:0]       last_step;

   assign last_step = ext_q ? 2'd2 : 2'd1;

   pgw_addr_gen #(
      .LIN_W(LIN_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)
   ) u_addr (
      .ext_i     (ext_q),
      .step_i    (step_q),
      .hi_word_i (hi_q),
      .lin_i     (lin_q),
      .base_i    (base_q),
      .frame_i   (frame_q),
      .addr_o    (mem_addr_o)
   );

   pgw_entry #(
      .PA_W(PA_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)
   ) u_entry (
      .ext_i     (ext_q),
      .lo_i      (lo_q),
      .rdata_i   (mem_rdata_i),
      .present_o (present),
      .frame_o   (frame_new)
   );

   assign busy_o    = (state_q != WK_IDLE);
   assign mem_req_o = (state_q == WK_ISSUE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= WK_IDLE;
         step_q        <= 2'd0;
         hi_q          <= 1'b0;
         ext_q         <= 1'b0;
         lin_q         <= '0;
         base_q        <= '0;
         frame_q       <= '0;
         lo_q          <= '0;
         done_o        <= 1'b0;
         fault_o       <= 1'b0;
         fault_level_o <= 2'd0;
         phys_addr_o   <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            WK_IDLE: begin
               if (start_i) begin
                  if (!paging_en_i) begin
                     done_o        <= 1'b1;
                     fault_o       <= 1'b0;
                     fault_level_o <= 2'd0;
                     phys_addr_o   <= {{PAD_W{1'b0}}, lin_addr_i};
                  end else begin
                     lin_q   <= lin_addr_i;
                     base_q  <= base_i;
                     ext_q   <= ext_mode_i;
                     step_q  <= 2'd0;
                     hi_q    <= 1'b0;
                     state_q <= WK_ISSUE;
                  end
               end
            end
            WK_ISSUE: begin
               state_q <= WK_WAIT;
            end
            WK_WAIT: begin
               if (mem_rvalid_i) begin
                  if (ext_q && !hi_q) begin
                     lo_q    <= mem_rdata_i;
                     hi_q    <= 1'b1;
                     state_q <= WK_ISSUE;
                  end else if (!present) begin
                     done_o        <= 1'b1;
                     fault_o       <= 1'b1;
                     fault_level_o <= step_q;
                     state_q       <= WK_IDLE;
                  end else if (step_q == last_step) begin
                     done_o        <= 1'b1;
                     fault_o       <= 1'b0;
                     fault_level_o <= 2'd0;
                     phys_addr_o   <= {frame_new, lin_q[PAGE_SHIFT-1:0]};
                     state_q       <= WK_IDLE;
                  end else begin
                     frame_q <= frame_new;
                     step_q  <= step_q + 2'd1;
                     hi_q    <= 1'b0;
                     state_q <= WK_ISSUE;
                  end
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
   parameter int LIN_W      = 32,
   parameter int PA_W       = 36,
   parameter int PAGE_SHIFT = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [LIN_W-1:0] lin_addr_i,
   input logic             paging_en_i,
   input logic             ext_mode_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             fault_o,
   input logic [1:0]       fault_level_o,
   input logic [PA_W-1:0]  phys_addr_o,
   input logic             mem_req_o,
   input logic [PA_W-1:0]  mem_addr_o
);
   logic             ext_seen;
   logic [LIN_W-1:0] lin_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_seen <= 1'b0;
         lin_seen <= '0;
      end else if (start_i && !busy_o) begin
         ext_seen <= ext_mode_i & paging_en_i;
         lin_seen <= lin_addr_i;
      end
   end

   p_identity_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !paging_en_i) |=>
      (done_o && !fault_o && !mem_req_o &&
       phys_addr_o == {{(PA_W-LIN_W){1'b0}}, $past(lin_addr_i)}));

   p_short_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !ext_seen) |->
      (mem_addr_o[1:0] == 2'b00 && mem_addr_o[PA_W-1:LIN_W] == '0));

   p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fault_o) |->
      phys_addr_o[PAGE_SHIFT-1:0] == lin_seen[PAGE_SHIFT-1:0]);

   p_long_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && ext_seen) |-> mem_addr_o[1:0] == 2'b00);

   p_fault_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o) |-> (fault_level_o <= (ext_seen ? 2'd2 : 2'd1)));

   p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o);

   p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> busy_o);

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !mem_req_o));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);
endmodule

bind page_walker page_walker_chk #(
   .LIN_W(LIN_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .lin_addr_i    (lin_addr_i),
   .paging_en_i   (paging_en_i),
   .ext_mode_i    (ext_mode_i),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .fault_o       (fault_o),
   .fault_level_o (fault_level_o),
   .phys_addr_o   (phys_addr_o),
   .mem_req_o     (mem_req_o),
   .mem_addr_o    (mem_addr_o)
);

// File: tb/page_walker_test.sv
`timescale 1ns/1ps
module page_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] lin_addr_i = '0;
   logic [31:0] base_i = '0;
   logic        paging_en_i = 1'b0;
   logic        ext_mode_i = 1'b0;
   logic        busy_o, done_o, fault_o, mem_req_o;
   logic [1:0]  fault_level_o;
   logic [35:0] phys_addr_o, mem_addr_o;
   logic        mem_rvalid_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;

   always #2.5 clk = ~clk;

   page_walker uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .lin_addr_i(lin_addr_i),
      .base_i(base_i), .paging_en_i(paging_en_i), .ext_mode_i(ext_mode_i),
      .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
      .fault_level_o(fault_level_o), .phys_addr_o(phys_addr_o),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
      .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
   );

   int n_checks = 0;
   int n_fails  = 0;
   int lat_cfg  = 0;
   logic [35:0] fault_addr = '1;

   // memory model: word contents are a fixed hash of the address
   function automatic logic [31:0] memf(input logic [35:0] a);
      logic [31:0] w;
      w = (a[31:0] * 32'h9E37_79B1) ^ {a[35:32], 28'h0} ^ 32'h1357_9BDF;
      w[0] = (a != fault_addr);
      return w;
   endfunction

   logic        pend = 1'b0;
   int          cnt = 0;
   logic [35:0] maddr = '0;
   int          nreads = 0;
   logic [35:0] addr_log [0:15];

   always @(posedge clk) begin
      mem_rvalid_i <= 1'b0;
      if (mem_req_o) begin
         pend  <= 1'b1;
         cnt   <= lat_cfg;
         maddr <= mem_addr_o;
         if (nreads < 16) addr_log[nreads] <= mem_addr_o;
         nreads <= nreads + 1;
      end else if (pend) begin
         if (cnt == 0) begin
            mem_rvalid_i <= 1'b1;
            mem_rdata_i  <= memf(maddr);
            pend         <= 1'b0;
         end else begin
            cnt <= cnt - 1;
         end
      end
   end

   task automatic check(input logic ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // reference walk
   int          e_n;
   logic [35:0] e_addr [0:7];
   logic        e_fault;
   logic [1:0]  e_lvl;
   logic [35:0] e_phys;

   task automatic model_walk(input logic ext, input logic [31:0] lin, input logic [31:0] base);
      logic [35:0] a;
      logic [31:0] lo, hi;
      logic [23:0] fr;
      logic        stop;
      e_n = 0; e_fault = 1'b0; e_lvl = 2'd0; e_phys = '0; stop = 1'b0;
      if (!ext) begin
         a = {4'h0, base[31:12], lin[31:22], 2'b00};
         for (int s = 0; s < 2; s++) begin
            if (!stop) begin
               lo = memf(a);
               e_addr[e_n] = a; e_n++;
               fr = {4'h0, lo[31:12]};
               if (!lo[0]) begin
                  e_fault = 1'b1; e_lvl = 2'(s); stop = 1'b1;
               end else if (s == 1) begin
                  e_phys = {fr, lin[11:0]};
               end else begin
                  a = {fr, lin[21:12], 2'b00};
               end
            end
         end
      end else begin
         a = {4'h0, base[31:5], lin[31:30], 3'b000};
         for (int s = 0; s < 3; s++) begin
            if (!stop) begin
               lo = memf(a);
               hi = memf(a | 36'h4);
               e_addr[e_n] = a; e_addr[e_n+1] = a | 36'h4; e_n += 2;
               fr = {hi[3:0], lo[31:12]};
               if (!lo[0]) begin
                  e_fault = 1'b1; e_lvl = 2'(s); stop = 1'b1;
               end else if (s == 2) begin
                  e_phys = {fr, lin[11:0]};
               end else begin
                  a = {fr, (s == 0) ? lin[29:21] : lin[20:12], 3'b000};
               end
            end
         end
      end
   endtask

   task automatic run_walk(input logic ext, input logic [31:0] lin, input logic [31:0] base,
                           input logic paging, input int lat, input int fsel);
      int cyc;
      string rq_res, rq_lo;
      fault_addr = '1;
      model_walk(ext, lin, base);
      if (paging && fsel < (ext ? 3 : 2)) begin
         fault_addr = e_addr[ext ? 2*fsel : fsel];
         model_walk(ext, lin, base);
      end
      rq_res = ext ? "R6" : "R3";
      rq_lo  = ext ? "R4" : "R2";
      lat_cfg = lat;
      @(negedge clk);
      nreads = 0;
      start_i = 1'b1; lin_addr_i = lin; base_i = base;
      paging_en_i = paging; ext_mode_i = ext;
      @(negedge clk);
      start_i = 1'b0;
      if (!paging) begin
         check(done_o === 1'b1, "R1", "identity done", 64'(done_o), 64'd1);
         check(fault_o === 1'b0, "R1", "identity fault", 64'(fault_o), 64'd0);
         check(phys_addr_o === {4'h0, lin}, "R1", "identity phys", 64'(phys_addr_o), 64'({4'h0, lin}));
         @(negedge clk);
         check(nreads == 0, "R1", "identity reads", 64'(nreads), 64'd0);
         check(done_o === 1'b0, "R9", "done pulse width", 64'(done_o), 64'd0);
         return;
      end
      check(busy_o === 1'b1, "R9", "busy after start", 64'(busy_o), 64'd1);
      if (lat == 2) begin
         // R9: a start while busy must not disturb the walk
         start_i = 1'b1; lin_addr_i = ~lin; base_i = ~base;
         paging_en_i = 1'b0; ext_mode_i = ~ext;
         @(negedge clk);
         start_i = 1'b0;
      end
      cyc = 0;
      while (done_o !== 1'b1 && cyc < 300) begin
         @(negedge clk);
         cyc++;
      end
      check(cyc < 300, "R8", "walk completes", 64'(cyc), 64'd0);
      check(busy_o === 1'b0, "R9", "idle at done", 64'(busy_o), 64'd0);
      check(fault_o === e_fault, "R7", "fault flag", 64'(fault_o), 64'(e_fault));
      if (e_fault)
         check(fault_level_o === e_lvl, "R7", "fault level", 64'(fault_level_o), 64'(e_lvl));
      else
         check(phys_addr_o === e_phys, rq_res, "physical address", 64'(phys_addr_o), 64'(e_phys));
      check(nreads == e_n, "R8", "read count", 64'(nreads), 64'(e_n));
      for (int k = 0; k < e_n && k < nreads && k < 8; k++) begin
         if (ext && (k % 2 == 1))
            check(addr_log[k] === e_addr[k], "R5", "high word address", 64'(addr_log[k]), 64'(e_addr[k]));
         else
            check(addr_log[k] === e_addr[k], rq_lo, "entry address", 64'(addr_log[k]), 64'(e_addr[k]));
      end
      @(negedge clk);
      check(done_o === 1'b0, "R9", "done pulse width", 64'(done_o), 64'd0);
   endtask

   function automatic logic [31:0] pick_lin(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'hFFFF_FFFF;
         2: return 32'h8000_0000;
         3: return 32'h3FFF_FFFF;
         4: return 32'h0040_0FFF;
         5: return 32'hC020_1001;
         default: return (32'(i) * 32'h2F1D_4B87) + 32'h0C03_0201;
      endcase
   endfunction

   bit finished = 1'b0;

   initial begin
      int cycles = 0;
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] bases [0:2];
      bases[0] = 32'h0012_34A7;
      bases[1] = 32'hFEDC_BFFF;
      bases[2] = 32'h0000_0020;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_o === 1'b0, "R9", "reset busy", 64'(busy_o), 64'd0);
      check(done_o === 1'b0, "R9", "reset done", 64'(done_o), 64'd0);
      check(mem_req_o === 1'b0, "R8", "reset request", 64'(mem_req_o), 64'd0);

      for (int i = 0; i < 24; i++)
         run_walk(1'(i), pick_lin(i), bases[i % 3], 1'b0, 0, 3);

      for (int m = 0; m < 2; m++)
         for (int b = 0; b < 3; b++)
            for (int i = 0; i < 24; i++)
               for (int l = 0; l < 4; l++)
                  run_walk(1'(m), pick_lin(i), bases[b], 1'b1, l, (i + l + b) % 4);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule